// File: doc/BRIEF.md
# Dual-path SPI bit-clock divider

This block turns a fast source clock into the timing for an SPI shift engine. It does not make a new clock. It produces a serial-clock level and two single-cycle strobes in the source domain. One strobe fires when the serial clock leaves its idle level and the other fires when it returns to idle. The shift engine uses them as its launch and sample points.

The half period can come from either of two dividers, chosen by a select input:
- **Power-of-two path:** a 3-bit code N gives an overall divide of 4·2^N.
- **Linear path:** an 8-bit code N gives an overall divide of 2·(N+1).

Counting starts again from the idle phase each time a burst starts. Divider settings are taken only while the block is held, so a change made during a burst cannot disturb a word that is being shifted.

Top module: `spi_bitclk_div`

## Requirements
- R1: While reset is asserted, `sclk` equals `idlePol`, and `leadPulse` and `trailPulse` are 0.
- R2: With `pathSel`=0, the half period is 2^(`powCode`+1) source cycles. Code 0 gives a full period of 4 cycles, and code 7 gives 512 cycles.
- R3: With `pathSel`=1, the half period is `linCode`+1 source cycles. Code 0 gives a full period of 2 cycles, and code 255 gives 512 cycles.
- R4: `pathSel` picks the divider. The code of the path that is not selected has no effect on timing.
- R5: While `enable` is 0, the counter is cleared, `sclk` rests at `idlePol`, and neither strobe fires.
- R6: A `burstStart` pulse sampled high returns `sclk` to idle with no strobe in that cycle. This is true even when a toggle was due in the same cycle.
- R7: Divider codes are sampled only on cycles where `enable` is 0 or `burstStart` is 1. A code changed during a run leaves the current half period unchanged until the next such cycle.
- R8: `leadPulse` is high for one cycle as `sclk` leaves `idlePol`. `trailPulse` is high for one cycle as `sclk` returns to it. The two are never high together.
- R9: For a half period of H cycles, the first `leadPulse` appears on the H-th enabled clock edge after `enable` rises. After a `burstStart` edge, it appears H edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run gate; low holds the divider idle |
| burstStart | input | 1 | One-cycle pulse that restarts the phase and samples the codes |
| pathSel | input | 1 | 0 selects the power-of-two path, 1 selects the linear path |
| powCode | input | 3 | Exponent for the power-of-two path |
| linCode | input | 8 | Linear divide code for the linear path |
| idlePol | input | 1 | Resting level of the serial clock |
| sclk | output | 1 | Serial clock level |
| leadPulse | output | 1 | Strobe when sclk leaves idle |
| trailPulse | output | 1 | Strobe when sclk returns to idle |

## Verification
Two functions can fall on the same clock edge:
- A burst restart can land on the edge where a half-period toggle is due. The bench provokes this with a 3-cycle half period and a `burstStart` placed exactly on the third edge after a restart. It judges the result by seeing no strobe and an idle `sclk` in that cycle, with the next leading strobe three edges later.
- A code change can arrive together with a restart. The bench provokes this by changing `linCode` during a run and then restarting. It checks that the old period holds until the restart and that the new one applies from the restart onward.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // Strobes from the control counter to the clock-phase datapath.
  typedef struct packed {
    logic hold;    // clear phase, reload divider codes
    logic toggle;  // half-period boundary reached
  } divStrobe_t;
endpackage

// File: rtl/spi_div_ctrl.sv
module spi_div_ctrl
  import spi_div_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int LIN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             burstStart,
  input  logic             pathSel,
  input  logic [POW_W-1:0] powCode,
  input  logic [LIN_W-1:0] linCode,
  output divStrobe_t       strobe
);
  logic [CNT_W:0]   powSpan;
  logic [CNT_W-1:0] nextLast;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] cnt;

  // Half period minus one: power-of-two path is 2^(N+1)-1, linear path is N.
  always_comb begin
    powSpan  = (CNT_W+1)'(1) << ({1'b0, powCode} + 1'b1);
    nextLast = pathSel ? CNT_W'(linCode) : CNT_W'(powSpan - 1'b1);
  end

  assign strobe.hold   = !enable || burstStart;
  assign strobe.toggle = !strobe.hold && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      lastCnt <= '0;
    end else if (strobe.hold) begin
      cnt     <= '0;
      lastCnt <= nextLast;
    end else if (cnt == lastCnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: codes are frozen while running
  a_r7_codes_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hold |=> $stable(lastCnt));
  // R2 / R3: the count never runs past the sampled limit
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);
  // R5: a hold always leaves the counter cleared
  a_r5_hold_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (cnt == '0));
endmodule

// File: rtl/spi_div_dp.sv
module spi_div_dp
  import spi_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  input  logic       idlePol,
  output logic       sclk,
  output logic       leadPulse,
  output logic       trailPulse
);
  logic phase;  // 0 = idle level, 1 = active level
  logic tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
      tickQ <= 1'b0;
    end else if (strobe.hold) begin
      phase <= 1'b0;
      tickQ <= 1'b0;
    end else if (strobe.toggle) begin
      phase <= ~phase;
      tickQ <= 1'b1;
    end else begin
      tickQ <= 1'b0;
    end
  end

  assign sclk       = phase ^ idlePol;
  assign leadPulse  = tickQ & phase;
  assign trailPulse = tickQ & ~phase;

  // R8: every strobe coincides with a level change of the serial clock
  a_r8_strobe_moves_clock: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |-> (phase != $past(phase)));
  // R8: a strobe never repeats on consecutive cycles of the same kind
  a_r8_lead_single: assert property (@(posedge clk) disable iff (!rstN)
    leadPulse |=> !leadPulse);
  // R6: a restart yields idle with no strobe on the next cycle
  a_r6_restart_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (!tickQ && !phase));
endmodule

// File: rtl/spi_bitclk_div.sv
module spi_bitclk_div
  import spi_div_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             burstStart,
  input  logic             pathSel,
  input  logic [POW_W-1:0] powCode,
  input  logic [LIN_W-1:0] linCode,
  input  logic             idlePol,
  output logic             sclk,
  output logic             leadPulse,
  output logic             trailPulse
);
  // Counter must hold the largest half period minus one of either path.
  localparam int POW_MAX_EXP = 2 ** POW_W;
  localparam int CNT_W = (POW_MAX_EXP > LIN_W) ? POW_MAX_EXP : LIN_W;

  divStrobe_t strobe;

  spi_div_ctrl #(.POW_W(POW_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .burstStart(burstStart),
    .pathSel(pathSel), .powCode(powCode), .linCode(linCode), .strobe(strobe)
  );

  spi_div_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idlePol(idlePol),
    .sclk(sclk), .leadPulse(leadPulse), .trailPulse(trailPulse)
  );

  // R1: outputs quiet and at idle under reset
  always_comb begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (sclk == idlePol && !leadPulse && !trailPulse);
    end
  end
endmodule

// File: tb/sim_spi_bitclk_div.sv
module sim_spi_bitclk_div;
  logic clk = 1'b0;
  logic rstN, enable, burstStart, pathSel, idlePol;
  logic [2:0] powCode;
  logic [7:0] linCode;
  logic sclk, leadPulse, trailPulse;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_bitclk_div u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .burstStart(burstStart),
    .pathSel(pathSel), .powCode(powCode), .linCode(linCode), .idlePol(idlePol),
    .sclk(sclk), .leadPulse(leadPulse), .trailPulse(trailPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Count negedges until the chosen strobe is seen (k=1 is the first negedge).
  task automatic waitEdge(input bit wantLead, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(wantLead ? leadPulse : trailPulse) && k < 2000);
  endtask

  task automatic cfg(input bit sel, input int pw, input int ln, input bit pol);
    @(negedge clk);
    enable = 0; pathSel = sel; powCode = 3'(pw); linCode = 8'(ln); idlePol = pol;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rate(input string req, input bit sel, input int pw,
                        input int ln, input bit pol, input int h);
    int k;
    cfg(sel, pw, ln, pol);
    enable = 1;
    waitEdge(1, k);  chk({req, " R9 first lead"}, k, h);
    chk({req, " R8 active level"}, sclk, !pol);
    chk({req, " R8 no trail with lead"}, trailPulse, 0);
    waitEdge(0, k);  chk({req, " high half"}, k, h);
    chk({req, " R8 idle after trail"}, sclk, pol);
    waitEdge(1, k);  chk({req, " low half"}, k, h);
  endtask

  task automatic t_reset();
    chk("R1 sclk idle0", sclk, 0);
    chk("R1 no strobes", leadPulse | trailPulse, 0);
    idlePol = 1; #1;
    chk("R1 sclk idle1", sclk, 1);
    idlePol = 0;
  endtask

  task automatic t_disable();
    int k;
    cfg(1, 0, 3, 0);
    enable = 1;
    waitEdge(1, k);
    enable = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5 idle when disabled", sclk, 0);
      chk("R5 no strobe when disabled", leadPulse | trailPulse, 0);
    end
    enable = 1;
    waitEdge(1, k);  chk("R9 lead after re-enable", k, 4);
  endtask

  task automatic t_restart_and_collide();
    int k;
    cfg(1, 0, 2, 0);  // half period 3
    enable = 1;
    waitEdge(1, k);
    burstStart = 1;
    @(negedge clk);
    burstStart = 0;
    chk("R6 idle after restart", sclk, 0);
    chk("R6 no strobe on restart", leadPulse, 0);
    repeat (2) @(negedge clk);  // next toggle is due on the coming edge
    burstStart = 1;
    @(negedge clk);
    burstStart = 0;
    chk("R6 collide no lead", leadPulse, 0);
    chk("R6 collide idle", sclk, 0);
    waitEdge(1, k);  chk("R9 lead after collide restart", k, 3);
  endtask

  task automatic t_midchange();
    int k;
    cfg(1, 6, 1, 0);  // half period 2
    enable = 1;
    waitEdge(1, k);
    linCode = 8'd5; powCode = 3'd0;
    waitEdge(0, k);  chk("R7 old half kept", k, 2);
    waitEdge(1, k);  chk("R7 old half kept again", k, 2);
    burstStart = 1;
    @(negedge clk);
    burstStart = 0;
    waitEdge(1, k);  chk("R7 new half after restart", k, 6);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; enable = 0; burstStart = 0; pathSel = 0; idlePol = 0;
    powCode = 0; linCode = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_rate("R2 pow0", 0, 0, 77, 0, 2);
    t_rate("R2 pow2", 0, 2, 9, 0, 8);
    t_rate("R2 pow7", 0, 7, 0, 0, 256);
    t_rate("R3 lin0 pol1", 1, 5, 0, 1, 1);
    t_rate("R3 lin4 R4", 1, 7, 4, 0, 5);
    t_rate("R3 lin255", 1, 0, 255, 1, 256);
    t_disable();
    t_restart_and_collide();
    t_midchange();
    summary();
    $finish;
  end
endmodule